// File: doc/BRIEF.md
# Frame Buffer Header Decoder and Validator

Once per refresh request, this block looks at the leading 16-bit word stored at the head of the current frame buffer. From a three-bit code inside that word it decides how many bits each pixel uses. It works out how many bytes of embedded colour table come before the pixel data. It then checks that the programmed resolution, at that depth, fits inside the selected buffer region.

When the check passes, the block reports the frame to the DMA side and computes the address where pixel data begins. It gives the line stride in bytes and applies the partial-panel setting, which picks either the first shown line or a reduced active height. In dual-buffer operation it then swaps to the other buffer.

A single-cycle `start` latches every input. Two clock edges later exactly one of three one-cycle result pulses appears:
- `ok` when the frame is accepted;
- `fail` when the update is aborted or the size check fails;
- `skip` when no refresh work is due.

Top module: `fb_header_check`

## Requirements
- R1: After reset `ok`, `fail`, `sync_fail`, `skip`, `dma_irq` and `cond_set` are low and `cur_buf` is 0.
- R2: With `panel_en` low or `load_mode` equal to 1, an accepted start yields only a `skip` pulse; `cur_buf` does not change.
- R3: The depth code is `hdr_word[14:12]`: code 1 gives `bpp`=2, code 2 gives 4, code 3 gives 8, codes 4 to 7 give 16.
- R4: Depth code 0 yields a `fail` pulse with `sync_fail` low and no buffer change.
- R5: `color12` is 1 exactly when `bpp` is 16 and `active_matrix` is 0.
- R6: `pix_offset` is 0 when `load_mode` is 2. Otherwise it is 512 for codes 3 to 7 and 32 for codes 1 and 2. `frame_base` is the top address of buffer `cur_buf` plus `pix_offset`.
- R7: The needed byte count is `pix_offset` + width*height*bpp/8. If it is larger than (bottom - top of buffer `cur_buf`) + 2, the block pulses `fail` and `sync_fail` together; if it equals that limit, the frame is accepted.
- R8: On `ok`, `cond_set` pulses with only bit `cur_buf` set, and `dma_irq` pulses alongside it when `dma_irq_en` is 1.
- R9: After `ok` with `dual_buf` 1, `cur_buf` toggles; a failure or a skip never toggles it.
- R10: When `subpanel[31]` is 1 and `subpanel[29]` is 1, `first_line` = `subpanel[25:16]` and `act_height` = `height`. When bit 31 is 1 and bit 29 is 0, `first_line` = 0 and `act_height` = `subpanel[25:16]`. When bit 31 is 0, `first_line` = 0 and `act_height` = `height`.
- R11: `stride` equals (width*bpp)>>3.
- R12: A start taken while idle gives exactly one result pulse two edges later, lasting one cycle. A start during the busy cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Refresh request, latches all inputs |
| panel_en | input | 1 | Panel enabled |
| load_mode | input | 2 | Colour-table/frame load mode |
| active_matrix | input | 1 | Selects 16-bit instead of 12-bit colour at 16 bpp |
| dual_buf | input | 1 | Alternate between two buffers |
| dma_irq_en | input | 1 | DMA frame interrupt enable |
| hdr_word | input | 16 | First word of the frame buffer |
| width | input | DIM_W | Pixels per line |
| height | input | DIM_W | Lines per frame |
| subpanel | input | 32 | Partial-panel setting |
| top0 | input | ADDR_W | Buffer 0 start address |
| bot0 | input | ADDR_W | Buffer 0 end address |
| top1 | input | ADDR_W | Buffer 1 start address |
| bot1 | input | ADDR_W | Buffer 1 end address |
| ok | output | 1 | Frame accepted pulse |
| fail | output | 1 | Abort or size failure pulse |
| sync_fail | output | 1 | Size failure, panel enable must drop |
| skip | output | 1 | No refresh work pulse |
| bpp | output | 5 | Bits per pixel |
| color12 | output | 1 | 12-bit colour packing at 16 bpp |
| pix_offset | output | 10 | Bytes of colour table before pixels |
| frame_base | output | ADDR_W | Address of first pixel byte |
| stride | output | DIM_W+2 | Bytes per line |
| first_line | output | DIM_W | First shown line |
| act_height | output | DIM_W | Lines shown |
| cond_set | output | 2 | One-hot DMA condition pulse by buffer |
| dma_irq | output | 1 | DMA interrupt pulse |
| cur_buf | output | 1 | Current buffer index |

## Verification
The hardest case to reach is the exact edge of the size check, where the needed byte count sits at the region size plus two or one byte past it. To reach it, the stimulus picks a resolution and depth, then sets the buffer bottom address so that the region is two bytes short of the need, and then three bytes short. Buffer alternation is also hard to see, because `cur_buf` only moves on success. The stimulus runs dual-mode frames with different tops and bottoms per buffer and puts a failing frame between them, so a wrong buffer choice shows up in `frame_base` and `cond_set`.

// File: rtl/fb_header_check.sv
module fb_header_check #(
  parameter int DIM_W  = 11,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              panel_en,
  input  logic [1:0]        load_mode,
  input  logic              active_matrix,
  input  logic              dual_buf,
  input  logic              dma_irq_en,
  input  logic [15:0]       hdr_word,
  input  logic [DIM_W-1:0]  width,
  input  logic [DIM_W-1:0]  height,
  input  logic [31:0]       subpanel,
  input  logic [ADDR_W-1:0] top0,
  input  logic [ADDR_W-1:0] bot0,
  input  logic [ADDR_W-1:0] top1,
  input  logic [ADDR_W-1:0] bot1,
  output logic              ok,
  output logic              fail,
  output logic              sync_fail,
  output logic              skip,
  output logic [4:0]        bpp,
  output logic              color12,
  output logic [9:0]        pix_offset,
  output logic [ADDR_W-1:0] frame_base,
  output logic [DIM_W+1:0]  stride,
  output logic [DIM_W-1:0]  first_line,
  output logic [DIM_W-1:0]  act_height,
  output logic [1:0]        cond_set,
  output logic              dma_irq,
  output logic              cur_buf
);
  localparam int PROD_W = 2 * DIM_W;
  localparam int NEED_W = PROD_W + 2;
  localparam int CMP_W  = ADDR_W + 2;
  localparam int WB_W   = DIM_W + 5;

  logic              busy;
  logic [2:0]        code_q;
  logic [1:0]        mode_q;
  logic              en_q, am_q, dual_q, irq_q;
  logic [DIM_W-1:0]  w_q, h_q;
  logic [31:0]       sub_q;
  logic [ADDR_W-1:0] top0_q, bot0_q, top1_q, bot1_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      code_q <= '0;
      mode_q <= '0;
      en_q   <= 1'b0;
      am_q   <= 1'b0;
      dual_q <= 1'b0;
      irq_q  <= 1'b0;
      w_q    <= '0;
      h_q    <= '0;
      sub_q  <= '0;
      top0_q <= '0;
      bot0_q <= '0;
      top1_q <= '0;
      bot1_q <= '0;
    end else if (busy) begin
      busy <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      code_q <= hdr_word[14:12];
      mode_q <= load_mode;
      en_q   <= panel_en;
      am_q   <= active_matrix;
      dual_q <= dual_buf;
      irq_q  <= dma_irq_en;
      w_q    <= width;
      h_q    <= height;
      sub_q  <= subpanel;
      top0_q <= top0;
      bot0_q <= bot0;
      top1_q <= top1;
      bot1_q <= bot1;
    end
  end

  logic [4:0] bpp_c;
  always_comb begin
    case (code_q)
      3'd0:    bpp_c = 5'd0;
      3'd1:    bpp_c = 5'd2;
      3'd2:    bpp_c = 5'd4;
      3'd3:    bpp_c = 5'd8;
      default: bpp_c = 5'd16;
    endcase
  end

  logic [9:0] off_c;
  assign off_c = (mode_q == 2'd2) ? 10'd0 : (code_q >= 3'd3) ? 10'd512 : 10'd32;

  logic [PROD_W-1:0] prod;
  logic [NEED_W-1:0] pix_bytes, need;
  assign prod = w_q * h_q;
  always_comb begin
    case (code_q)
      3'd1:    pix_bytes = {2'b00, prod} >> 2;
      3'd2:    pix_bytes = {2'b00, prod} >> 1;
      3'd3:    pix_bytes = {2'b00, prod};
      default: pix_bytes = {1'b0, prod, 1'b0};
    endcase
  end
  assign need = pix_bytes + NEED_W'(off_c);

  logic [ADDR_W-1:0] top_sel, bot_sel;
  assign top_sel = cur_buf ? top1_q : top0_q;
  assign bot_sel = cur_buf ? bot1_q : bot0_q;

  logic signed [CMP_W-1:0] room, need_s;
  assign room   = $signed({2'b00, bot_sel}) - $signed({2'b00, top_sel}) + $signed(CMP_W'(2));
  assign need_s = $signed(CMP_W'(need));

  logic skip_c, nosup_c, big_c;
  assign skip_c  = !en_q || (mode_q == 2'd1);
  assign nosup_c = (code_q == 3'd0);
  assign big_c   = need_s > room;

  logic [WB_W-1:0] wb;
  assign wb = w_q * bpp_c;

  logic [DIM_W-1:0] fld;
  assign fld = DIM_W'(sub_q[25:16]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ok         <= 1'b0;
      fail       <= 1'b0;
      sync_fail  <= 1'b0;
      skip       <= 1'b0;
      bpp        <= '0;
      color12    <= 1'b0;
      pix_offset <= '0;
      frame_base <= '0;
      stride     <= '0;
      first_line <= '0;
      act_height <= '0;
      cond_set   <= '0;
      dma_irq    <= 1'b0;
      cur_buf    <= 1'b0;
    end else begin
      ok        <= 1'b0;
      fail      <= 1'b0;
      sync_fail <= 1'b0;
      skip      <= 1'b0;
      cond_set  <= '0;
      dma_irq   <= 1'b0;
      if (busy) begin
        if (skip_c) begin
          skip <= 1'b1;
        end else if (nosup_c) begin
          fail <= 1'b1;
        end else if (big_c) begin
          fail      <= 1'b1;
          sync_fail <= 1'b1;
        end else begin
          ok         <= 1'b1;
          bpp        <= bpp_c;
          color12    <= (bpp_c == 5'd16) && !am_q;
          pix_offset <= off_c;
          frame_base <= top_sel + ADDR_W'(off_c);
          stride     <= wb[WB_W-1:3];
          first_line <= (sub_q[31] && sub_q[29]) ? fld : '0;
          act_height <= (sub_q[31] && !sub_q[29]) ? fld : h_q;
          cond_set   <= cur_buf ? 2'b10 : 2'b01;
          dma_irq    <= irq_q;
          cur_buf    <= cur_buf ^ dual_q;
        end
      end
    end
  end

  p_one_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ok, fail, skip}));
  p_start_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |-> ##2 (ok || fail || skip));
  p_sync_is_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fail |-> fail);
  p_cond_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_set != 2'b00) |-> (ok && $countones(cond_set) == 1));
  p_irq_on_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_irq |-> ok);
  p_buf_moves_on_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_buf != $past(cur_buf)) |-> ok);
endmodule

// File: tb/test_fb_header_check.sv
module test_fb_header_check;
  localparam int DIM_W = 11;
  localparam int ADDR_W = 32;

  logic clk = 0, rst_n = 0, start = 0;
  logic panel_en = 0, active_matrix = 0, dual_buf = 0, dma_irq_en = 0;
  logic [1:0] load_mode = 0;
  logic [15:0] hdr_word = 0;
  logic [DIM_W-1:0] width = 0, height = 0;
  logic [31:0] subpanel = 0;
  logic [ADDR_W-1:0] top0 = 0, bot0 = 0, top1 = 0, bot1 = 0;
  logic ok, fail, sync_fail, skip, color12, dma_irq, cur_buf;
  logic [4:0] bpp;
  logic [9:0] pix_offset;
  logic [ADDR_W-1:0] frame_base;
  logic [DIM_W+1:0] stride;
  logic [DIM_W-1:0] first_line, act_height;
  logic [1:0] cond_set;

  fb_header_check #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) i_fb_header_check (
    .clk(clk), .rst_n(rst_n), .start(start), .panel_en(panel_en),
    .load_mode(load_mode), .active_matrix(active_matrix), .dual_buf(dual_buf),
    .dma_irq_en(dma_irq_en), .hdr_word(hdr_word), .width(width), .height(height),
    .subpanel(subpanel), .top0(top0), .bot0(bot0), .top1(top1), .bot1(bot1),
    .ok(ok), .fail(fail), .sync_fail(sync_fail), .skip(skip), .bpp(bpp),
    .color12(color12), .pix_offset(pix_offset), .frame_base(frame_base),
    .stride(stride), .first_line(first_line), .act_height(act_height),
    .cond_set(cond_set), .dma_irq(dma_irq), .cur_buf(cur_buf));

  always #4 clk = ~clk;

  int total = 0, bad = 0;

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_busy = 0, m_buf = 0;
  int L_code, L_mode, L_en, L_am, L_dual, L_irq, L_w, L_h;
  longint L_sub, L_t0, L_b0, L_t1, L_b1;
  int e_ok = 0, e_fail = 0, e_sync = 0, e_skip = 0, e_irq = 0, e_cond = 0;
  int e_bpp, e_c12, e_off, e_stride, e_first, e_height;
  longint e_base;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_buf = 0;
      e_ok = 0; e_fail = 0; e_sync = 0; e_skip = 0; e_irq = 0; e_cond = 0;
    end else begin
      e_ok = 0; e_fail = 0; e_sync = 0; e_skip = 0; e_irq = 0; e_cond = 0;
      if (m_busy != 0) begin
        int b, off;
        longint need, room, top, bot;
        m_busy = 0;
        b = (L_code == 0) ? 0 : (L_code == 1) ? 2 : (L_code == 2) ? 4 : (L_code == 3) ? 8 : 16;
        off = (L_mode == 2) ? 0 : (L_code >= 3) ? 512 : 32;
        top = (m_buf == 1) ? L_t1 : L_t0;
        bot = (m_buf == 1) ? L_b1 : L_b0;
        need = off + (longint'(L_w) * L_h * b) / 8;
        room = bot - top + 2;
        if (L_en == 0 || L_mode == 1) e_skip = 1;
        else if (L_code == 0) e_fail = 1;
        else if (need > room) begin e_fail = 1; e_sync = 1; end
        else begin
          e_ok = 1;
          e_bpp = b;
          e_c12 = (b == 16 && L_am == 0) ? 1 : 0;
          e_off = off;
          e_base = (top + off) & 64'hFFFF_FFFF;
          e_stride = (L_w * b) / 8;
          e_first = 0; e_height = L_h;
          if (L_sub[31]) begin
            if (L_sub[29]) e_first = int'((L_sub >> 16) & 1023);
            else e_height = int'((L_sub >> 16) & 1023);
          end
          e_cond = (m_buf == 1) ? 2 : 1;
          e_irq = L_irq;
          if (L_dual != 0) m_buf = 1 - m_buf;
        end
      end else if (start) begin
        m_busy = 1;
        L_code = int'(hdr_word[14:12]); L_mode = int'(load_mode); L_en = int'(panel_en);
        L_am = int'(active_matrix); L_dual = int'(dual_buf); L_irq = int'(dma_irq_en);
        L_w = int'(width); L_h = int'(height); L_sub = longint'(subpanel);
        L_t0 = longint'(top0); L_b0 = longint'(bot0); L_t1 = longint'(top1); L_b1 = longint'(bot1);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R12 ok pulse", ok, e_ok);
      chk("R4/R7 fail pulse", fail, e_fail);
      chk("R7 sync_fail", sync_fail, e_sync);
      chk("R2 skip pulse", skip, e_skip);
      chk("R8 cond_set", cond_set, e_cond);
      chk("R8 dma_irq", dma_irq, e_irq);
      chk("R9 cur_buf", cur_buf, m_buf);
      if (e_ok != 0) begin
        chk("R3 bpp", bpp, e_bpp);
        chk("R5 color12", color12, e_c12);
        chk("R6 pix_offset", pix_offset, e_off);
        chk("R6 frame_base", frame_base, e_base);
        chk("R11 stride", stride, e_stride);
        chk("R10 first_line", first_line, e_first);
        chk("R10 act_height", act_height, e_height);
      end
    end
  end

  task automatic frame(int code, int w, int h, int mode, int am, int dual, int irq, int en,
                       logic [31:0] sub, longint t0, longint b0, longint t1, longint b1,
                       int hold = 1);
    @(negedge clk);
    hdr_word = 16'(code << 12) | 16'h0A05;
    width = DIM_W'(w); height = DIM_W'(h); load_mode = 2'(mode);
    active_matrix = am[0]; dual_buf = dual[0]; dma_irq_en = irq[0]; panel_en = en[0];
    subpanel = sub; top0 = ADDR_W'(t0); bot0 = ADDR_W'(b0); top1 = ADDR_W'(t1); bot1 = ADDR_W'(b1);
    start = 1;
    repeat (hold) @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ok", ok, 0); chk("R1 fail", fail, 0); chk("R1 skip", skip, 0);
    chk("R1 sync_fail", sync_fail, 0); chk("R1 dma_irq", dma_irq, 0);
    chk("R1 cond_set", cond_set, 0); chk("R1 cur_buf", cur_buf, 0);
    rst_n = 1;
    // R2 skips
    frame(3, 10, 10, 0, 0, 1, 1, 0, 0, 'h1000, 'h2000, 'h3000, 'h4000);
    frame(3, 10, 10, 1, 0, 1, 1, 1, 0, 'h1000, 'h2000, 'h3000, 'h4000);
    // R4 unsupported
    frame(0, 10, 10, 0, 0, 1, 1, 1, 0, 'h1000, 'h2000, 'h3000, 'h4000);
    // R3/R6/R11 depths
    frame(1, 16, 8, 0, 0, 0, 1, 1, 0, 'h100, 'h200, 0, 0);
    frame(2, 20, 4, 0, 0, 0, 0, 1, 0, 'h100, 'h200, 0, 0);
    frame(3, 33, 5, 0, 1, 0, 1, 1, 0, 'h100, 'h400, 0, 0);
    frame(5, 17, 3, 0, 0, 0, 1, 1, 0, 'h100, 'h400, 0, 0);
    frame(7, 17, 3, 0, 1, 0, 1, 1, 0, 'h100, 'h400, 0, 0);
    frame(4, 1024, 768, 2, 1, 0, 1, 1, 0, 'h0, 'h200000, 0, 0);
    frame(1, 7, 3, 2, 0, 0, 0, 1, 0, 'h40, 'h80, 0, 0);
    // R7 boundary: need 612, room = 610+2 passes, 609+2 fails
    frame(3, 10, 10, 0, 0, 0, 1, 1, 0, 'h1000, 'h1000 + 610, 0, 0);
    frame(3, 10, 10, 0, 0, 0, 1, 1, 0, 'h1000, 'h1000 + 609, 0, 0);
    frame(6, 64, 64, 0, 0, 0, 1, 1, 0, 'h1000, 'h1100, 0, 0);
    // R9 dual alternation, failure does not toggle
    frame(3, 8, 8, 0, 0, 1, 1, 1, 0, 'h1000, 'h2000, 'h5000, 'h6000);
    frame(3, 8, 8, 0, 0, 1, 1, 1, 0, 'h1000, 'h2000, 'h5000, 'h6000);
    frame(3, 8, 8, 0, 0, 1, 1, 1, 0, 'h1000, 'h2000, 'h5000, 'h6000);
    frame(3, 80, 80, 0, 0, 1, 1, 1, 0, 'h1000, 'h2000, 'h5000, 'h5010);
    frame(3, 8, 8, 0, 0, 1, 0, 1, 0, 'h1000, 'h2000, 'h5000, 'h6000);
    frame(3, 8, 8, 0, 0, 1, 0, 0, 0, 'h1000, 'h2000, 'h5000, 'h6000);
    frame(0, 8, 8, 0, 0, 1, 0, 1, 0, 'h1000, 'h2000, 'h5000, 'h6000);
    frame(3, 8, 8, 0, 0, 1, 1, 1, 0, 'h1000, 'h2000, 'h5000, 'h6000);
    // R10 partial panel
    frame(2, 40, 30, 0, 0, 0, 1, 1, 32'hA00C_0000 | (32'd19 << 16), 'h100, 'h2000, 0, 0);
    frame(2, 40, 30, 0, 0, 0, 1, 1, 32'h8000_0000 | (32'd12 << 16), 'h100, 'h2000, 0, 0);
    frame(2, 40, 30, 0, 0, 0, 1, 1, 32'h2000_0000 | (32'd12 << 16), 'h100, 'h2000, 0, 0);
    frame(2, 40, 30, 0, 0, 0, 1, 1, 32'hA000_0000 | (32'd1023 << 16), 'h100, 'h2000, 0, 0);
    // R12 start held during busy cycle is ignored
    frame(3, 8, 8, 0, 0, 0, 1, 1, 0, 'h300, 'h800, 0, 0, 2);
    frame(1, 4, 4, 0, 0, 0, 1, 1, 0, 'h300, 'h800, 0, 0, 3);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule